// File: doc/BRIEF.md
# Coherence Directory Shard Engine

This block is one shard of a directory that keeps private L1 caches coherent in a small multicore. Cache-side controllers send it requests. Each request says whether it reads or writes, whether it is cached or uncached, and which cache should receive the answer. The engine replies with commands and gathers acknowledgements on a separate response channel. Every state change of a line is decided and recorded here and nowhere else. The cache controllers only carry out the commands they receive, so they need no transient protocol states and cannot race each other.

The shard tracks a fixed set of lines. For each line it keeps a state (I, S or M), a full-map holder vector and an owner index, and it holds the backing data word. The line address has two parts. The low `SHARD_W` bits are the interleave field, which picks the shard. The bits above them select the directory entry. The engine serves one transaction at a time: a new request is not taken until the last acknowledgement of the current one has come back and the closing command has been sent. Setting `PROTO_MSI` to 0 runs the simpler valid/invalid protocol. In that mode every cached access needs exclusive ownership.

Top module: `coh_dir_engine`

## Requirements
- R1: After reset `req_ready` and `rsp_ready` are 1, `cmd_valid` is 0, every entry is I with no holders, and every stored data word is 0.
- R2: Once a request is accepted, `req_ready` stays 0 and no further request is taken until the transaction's last command has been accepted. `req_ready` and `cmd_valid` are never 1 together.
- R3: Command type codes are FILL=0, SETST=1, INV=2, FWD=3, DONE=4, UCDATA=5 and UCDONE=6. State codes are I=0, S=1, M=2. A cached read of a line in I, or in S, by a cache that does not hold it, gets FILL with state S and the stored data. After the acknowledgement the requester is added as a holder.
- R4: A cached write to a line in S sends INV to every holder other than the requester, in ascending cache-index order. No grant is issued until every INV has been acknowledged. The grant is SETST with state M if the requester already held the line, and FILL with state M and the stored data otherwise.
- R5: A cached read of a line in M owned by another cache sends FWD to the owner, with `cmd_target` set to the requester and state S. The owner's acknowledgement carries data (`rsp_has_data`=1), and that data replaces the stored word. The engine then sends SETST with state S to the requester, and afterwards both caches are holders in S.
- R6: A cached write to a line in M owned by another cache sends FWD to the owner with state I. After the acknowledgement with data, the engine sends SETST with state M to the requester, which becomes the sole holder and owner.
- R7: Each cached transaction closes with a DONE command to the requester, sent only after the grant has been acknowledged. The directory entry is updated when DONE is accepted.
- R8: An uncached read gets a single UCDATA carrying the stored word. An uncached write stores `req_data` and gets a single UCDONE. Neither waits for an acknowledgement, and neither changes the line's state or holders.
- R9: With `PROTO_MSI`=0 a cached read behaves as a write. It is granted with state M (valid), and the previous owner receives FWD with state I.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, the command and all of its fields stay unchanged.
- R11: The directory entry is selected by `req_addr[LADDR_W-1:SHARD_W]`. The interleave bits do not take part in the lookup, and `cmd_addr` returns the full address of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_uncached | input | 1 | 1 = uncached access |
| req_src | input | ID_W | Requesting cache index |
| req_addr | input | LADDR_W | Line address |
| req_data | input | DATA_W | Write data for uncached writes |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken by destination |
| cmd_type | output | 3 | Command code |
| cmd_dest | output | ID_W | Cache that receives the command |
| cmd_target | output | ID_W | Receiver of a forwarded line |
| cmd_state | output | 2 | Line state to install |
| cmd_addr | output | LADDR_W | Line address of the transaction |
| cmd_data | output | DATA_W | Line data for FILL and UCDATA |
| rsp_valid | input | 1 | Acknowledgement present |
| rsp_ready | output | 1 | Acknowledgements always accepted |
| rsp_has_data | input | 1 | Acknowledgement carries a line |
| rsp_data | input | DATA_W | Returned line data |

## Verification
The hardest situation to reach is a write that finds several holders and must hold back its grant while invalidation acknowledgements are still outstanding. To get there, the stimulus first builds up two holders through ordinary reads, each read separated by a completed transaction. A third cache then writes the line. The bench lets both INV commands go out, returns only one acknowledgement, and confirms that no command appears and that `req_ready` stays low before it releases the second acknowledgement. The forward paths are reached the same way, by letting one cache take M before another cache touches the line. This includes a second address that differs only in the interleave bit.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_e;

  typedef enum logic [2:0] {
    CM_FILL   = 3'd0,
    CM_SETST  = 3'd1,
    CM_INV    = 3'd2,
    CM_FWD    = 3'd3,
    CM_DONE   = 3'd4,
    CM_UCDATA = 3'd5,
    CM_UCDONE = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    E_IDLE, E_DECIDE, E_UC, E_INV, E_FWD, E_GRANT, E_WAIT, E_FIN
  } eng_e;
endpackage

// File: rtl/coh_dir_table.sv
module coh_dir_table #(
  parameter int ENTRIES = 16,
  parameter int NCACHE  = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ID_W   = $clog2(NCACHE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        rd_state,
  output logic [NCACHE-1:0] rd_shr,
  output logic [ID_W-1:0]   rd_owner,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_state,
  input  logic [NCACHE-1:0] wr_shr,
  input  logic [ID_W-1:0]   wr_owner
);
  logic [1:0]        st_q  [ENTRIES];
  logic [NCACHE-1:0] shr_q [ENTRIES];
  logic [ID_W-1:0]   own_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[e]  <= 2'd0;
        shr_q[e] <= '0;
        own_q[e] <= '0;
      end else if (ent_we) begin
        st_q[e]  <= wr_state;
        shr_q[e] <= wr_shr;
        own_q[e] <= wr_owner;
      end
    end
  end

  assign rd_state = st_q[rd_idx];
  assign rd_shr   = shr_q[rd_idx];
  assign rd_owner = own_q[rd_idx];
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_word
    logic w_en;
    assign w_en = wr_en && (idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem_q[e] <= '0;
      else if (w_en) mem_q[e] <= wr_data;
    end
  end

  assign rd_data = mem_q[idx];
endmodule

// File: rtl/coh_low_pick.sv
module coh_low_pick #(
  parameter int N  = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] mask,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coh_dir_engine.sv
module coh_dir_engine
  import coh_pkg::*;
#(
  parameter int NCACHE    = 4,
  parameter int ENTRIES   = 16,
  parameter int DATA_W    = 32,
  parameter int SHARD_W   = 1,
  parameter bit PROTO_MSI = 1'b1,
  localparam int ID_W     = $clog2(NCACHE),
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int LADDR_W  = IDX_W + SHARD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_uncached,
  input  logic [ID_W-1:0]    req_src,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [2:0]         cmd_type,
  output logic [ID_W-1:0]    cmd_dest,
  output logic [ID_W-1:0]    cmd_target,
  output logic [1:0]         cmd_state,
  output logic [LADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0]  cmd_data,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic               rsp_has_data,
  input  logic [DATA_W-1:0]  rsp_data
);
  localparam int CNT_W = ID_W + 1;

  // transaction registers
  eng_e               st_q, st_d;
  logic               wr_q, wr_d;
  logic               unc_q, unc_d;
  logic [ID_W-1:0]    src_q, src_d;
  logic [LADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic [NCACHE-1:0]  inv_q, inv_d;
  logic [CNT_W-1:0]   pend_q, pend_d;
  logic               fwd_q, fwd_d;
  logic               gnt_q, gnt_d;

  // directory and store interface
  logic [IDX_W-1:0]   idx;
  logic [1:0]         rd_state;
  logic [NCACHE-1:0]  rd_shr;
  logic [ID_W-1:0]    rd_owner;
  logic [DATA_W-1:0]  rd_data;
  logic               dir_we;
  logic [1:0]         dir_wstate;
  logic [NCACHE-1:0]  dir_wshr;
  logic [ID_W-1:0]    dir_wown;
  logic               st_we;
  logic [DATA_W-1:0]  st_wdata;

  logic [NCACHE-1:0]  src_oh, others;
  logic               holds, self_own;
  logic [ID_W-1:0]    pick_idx;
  logic               pick_any;
  logic               cmd_hs, ack_cmd, rsp_hs;
  logic [1:0]         gnt_state;

  assign idx      = addr_q[LADDR_W-1:SHARD_W];
  assign src_oh   = NCACHE'(1) << src_q;
  assign others   = rd_shr & ~src_oh;
  assign holds    = |(rd_shr & src_oh);
  assign self_own = (rd_state == LS_M) && (rd_owner == src_q);
  assign gnt_state = (wr_q || self_own) ? LS_M : LS_S;

  coh_dir_table #(.ENTRIES(ENTRIES), .NCACHE(NCACHE)) u_tab (
    .clk(clk), .rst_n(rst_n), .rd_idx(idx),
    .rd_state(rd_state), .rd_shr(rd_shr), .rd_owner(rd_owner),
    .wr_en(dir_we), .wr_idx(idx), .wr_state(dir_wstate),
    .wr_shr(dir_wshr), .wr_owner(dir_wown)
  );

  coh_line_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(idx), .rd_data(rd_data),
    .wr_en(st_we), .wr_data(st_wdata)
  );

  coh_low_pick #(.N(NCACHE)) u_pick (
    .mask(inv_q), .idx(pick_idx), .any(pick_any)
  );

  // command channel, derived from registered state only
  always_comb begin
    cmd_valid  = 1'b0;
    cmd_type   = CM_DONE;
    cmd_dest   = src_q;
    cmd_target = '0;
    cmd_state  = LS_I;
    cmd_data   = '0;
    unique case (st_q)
      E_UC: begin
        cmd_valid = 1'b1;
        cmd_type  = wr_q ? CM_UCDONE : CM_UCDATA;
        cmd_data  = wr_q ? '0 : rd_data;
      end
      E_FWD: begin
        cmd_valid  = 1'b1;
        cmd_type   = CM_FWD;
        cmd_dest   = rd_owner;
        cmd_target = src_q;
        cmd_state  = wr_q ? LS_I : LS_S;
      end
      E_INV: begin
        cmd_valid = pick_any;
        cmd_type  = CM_INV;
        cmd_dest  = pick_idx;
      end
      E_GRANT: begin
        cmd_valid = 1'b1;
        cmd_type  = (holds || fwd_q) ? CM_SETST : CM_FILL;
        cmd_state = gnt_state;
        cmd_data  = (holds || fwd_q) ? '0 : rd_data;
      end
      E_FIN: cmd_valid = 1'b1;
      default: ;
    endcase
  end

  assign cmd_addr  = cmd_valid ? addr_q : '0;
  assign req_ready = (st_q == E_IDLE);
  assign rsp_ready = 1'b1;
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign rsp_hs    = rsp_valid;
  assign ack_cmd   = cmd_hs && (st_q == E_INV || st_q == E_FWD || st_q == E_GRANT);

  // store writes: returned lines and uncached writes
  assign st_we    = (rsp_hs && rsp_has_data) || (st_q == E_UC && cmd_hs && wr_q);
  assign st_wdata = (rsp_hs && rsp_has_data) ? rsp_data : data_q;

  // directory commit on DONE acceptance
  always_comb begin
    dir_we     = (st_q == E_FIN) && cmd_hs;
    dir_wstate = LS_S;
    dir_wshr   = rd_shr | src_oh;
    dir_wown   = src_q;
    if (wr_q) begin
      dir_wstate = LS_M;
      dir_wshr   = src_oh;
    end else if (self_own) begin
      dir_wstate = LS_M;
      dir_wshr   = rd_shr;
    end
  end

  // next state
  always_comb begin
    st_d   = st_q;
    wr_d   = wr_q;
    unc_d  = unc_q;
    src_d  = src_q;
    addr_d = addr_q;
    data_d = data_q;
    inv_d  = inv_q;
    fwd_d  = fwd_q;
    gnt_d  = gnt_q;
    pend_d = pend_q + CNT_W'(ack_cmd) - CNT_W'(rsp_hs);
    unique case (st_q)
      E_IDLE: if (req_valid) begin
        wr_d   = req_write || (!PROTO_MSI && !req_uncached);
        unc_d  = req_uncached;
        src_d  = req_src;
        addr_d = req_addr;
        data_d = req_data;
        fwd_d  = 1'b0;
        gnt_d  = 1'b0;
        st_d   = req_uncached ? E_UC : E_DECIDE;
      end
      E_DECIDE: begin
        if (rd_state == LS_M && |others) begin
          st_d = E_FWD;
        end else if (wr_q && rd_state == LS_S && |others) begin
          inv_d = others;
          st_d  = E_INV;
        end else begin
          st_d = E_GRANT;
        end
      end
      E_UC: if (cmd_hs) st_d = E_IDLE;
      E_FWD: if (cmd_hs) begin
        fwd_d = 1'b1;
        st_d  = E_WAIT;
      end
      E_INV: if (cmd_hs) begin
        inv_d = inv_q & ~(NCACHE'(1) << pick_idx);
        if (inv_d == '0) st_d = E_WAIT;
      end
      E_GRANT: if (cmd_hs) begin
        gnt_d = 1'b1;
        st_d  = E_WAIT;
      end
      E_WAIT: if (pend_q == '0) st_d = gnt_q ? E_FIN : E_GRANT;
      E_FIN: if (cmd_hs) st_d = E_IDLE;
      default: st_d = E_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      wr_q   <= 1'b0;
      unc_q  <= 1'b0;
      src_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      inv_q  <= '0;
      pend_q <= '0;
      fwd_q  <= 1'b0;
      gnt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wr_q   <= wr_d;
      unc_q  <= unc_d;
      src_q  <= src_d;
      addr_q <= addr_d;
      data_q <= data_d;
      inv_q  <= inv_d;
      pend_q <= pend_d;
      fwd_q  <= fwd_d;
      gnt_q  <= gnt_d;
    end
  end
endmodule

// File: rtl/coh_dir_engine_chk.sv
module coh_dir_engine_chk #(
  parameter int NCACHE = 4,
  parameter int DATA_W = 32,
  localparam int ID_W  = $clog2(NCACHE)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_type,
  input logic [ID_W-1:0]   cmd_dest,
  input logic [ID_W-1:0]   cmd_target,
  input logic [1:0]        cmd_state,
  input logic [DATA_W-1:0] cmd_data,
  input logic              dir_we,
  input logic [1:0]        dir_wstate,
  input logic [NCACHE-1:0] dir_wshr
);
  // R2
  req_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_type) && $stable(cmd_dest)
      && $stable(cmd_target) && $stable(cmd_state) && $stable(cmd_data));

  // R7
  fin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_type == 3'd4 |=> req_ready);

  // R8
  uc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_type == 3'd5 || cmd_type == 3'd6) |=> req_ready);

  // R6
  m_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we && dir_wstate == 2'd2 |-> $onehot(dir_wshr));

  // R3
  s_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we && dir_wstate == 2'd1 |-> dir_wshr != '0);
endmodule

bind coh_dir_engine coh_dir_engine_chk #(.NCACHE(NCACHE), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
  .cmd_dest(cmd_dest), .cmd_target(cmd_target), .cmd_state(cmd_state),
  .cmd_data(cmd_data), .dir_we(dir_we), .dir_wstate(dir_wstate), .dir_wshr(dir_wshr)
);

// File: tb/sim_coh_dir_engine.sv
module sim_coh_dir_engine;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic          req_valid [2], req_ready [2], req_write [2], req_uncached [2];
  logic [1:0]    req_src   [2];
  logic [AW-1:0] req_addr  [2];
  logic [DW-1:0] req_data  [2];
  logic          cmd_valid [2], cmd_ready [2];
  logic [2:0]    cmd_type  [2];
  logic [1:0]    cmd_dest  [2], cmd_target [2], cmd_state [2];
  logic [AW-1:0] cmd_addr  [2];
  logic [DW-1:0] cmd_data  [2];
  logic          rsp_valid [2], rsp_ready [2], rsp_has_data [2];
  logic [DW-1:0] rsp_data  [2];

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  coh_dir_engine #(.PROTO_MSI(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_write(req_write[0]), .req_uncached(req_uncached[0]), .req_src(req_src[0]),
    .req_addr(req_addr[0]), .req_data(req_data[0]), .cmd_valid(cmd_valid[0]),
    .cmd_ready(cmd_ready[0]), .cmd_type(cmd_type[0]), .cmd_dest(cmd_dest[0]),
    .cmd_target(cmd_target[0]), .cmd_state(cmd_state[0]), .cmd_addr(cmd_addr[0]),
    .cmd_data(cmd_data[0]), .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]),
    .rsp_has_data(rsp_has_data[0]), .rsp_data(rsp_data[0]));

  coh_dir_engine #(.PROTO_MSI(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_write(req_write[1]), .req_uncached(req_uncached[1]), .req_src(req_src[1]),
    .req_addr(req_addr[1]), .req_data(req_data[1]), .cmd_valid(cmd_valid[1]),
    .cmd_ready(cmd_ready[1]), .cmd_type(cmd_type[1]), .cmd_dest(cmd_dest[1]),
    .cmd_target(cmd_target[1]), .cmd_state(cmd_state[1]), .cmd_addr(cmd_addr[1]),
    .cmd_data(cmd_data[1]), .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]),
    .rsp_has_data(rsp_has_data[1]), .rsp_data(rsp_data[1]));

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(int u, bit wr, bit unc, int src, int addr, int data);
    @(negedge clk);
    req_write[u] = wr; req_uncached[u] = unc; req_src[u] = 2'(src);
    req_addr[u] = AW'(addr); req_data[u] = DW'(data); req_valid[u] = 1'b1;
    while (!req_ready[u]) @(negedge clk);
    @(negedge clk);
    req_valid[u] = 1'b0;
  endtask

  // wait for a command, check it, then accept it; est/edata < 0 skip the field
  task automatic get_cmd(int u, string rq, int etype, int edest, int etgt, int est, int edata);
    int w = 0;
    while (!cmd_valid[u] && w < 40) begin @(negedge clk); w++; end
    chk(cmd_valid[u] == 1'b1, rq, "cmd_valid", int'(cmd_valid[u]), 1);
    chk(int'(cmd_type[u]) == etype && int'(cmd_dest[u]) == edest, rq, "type/dest",
        int'({cmd_type[u], 2'b0, cmd_dest[u]}), (etype << 4) | edest);
    if (etgt >= 0) chk(int'(cmd_target[u]) == etgt, rq, "target", int'(cmd_target[u]), etgt);
    if (est >= 0)  chk(int'(cmd_state[u]) == est, rq, "state", int'(cmd_state[u]), est);
    if (edata >= 0) chk(int'(cmd_data[u]) == edata, rq, "data", int'(cmd_data[u]), edata);
    cmd_ready[u] = 1'b1;
    @(negedge clk);
    cmd_ready[u] = 1'b0;
  endtask

  task automatic send_ack(int u, bit hasd, int d);
    rsp_valid[u] = 1'b1; rsp_has_data[u] = hasd; rsp_data[u] = DW'(d);
    @(negedge clk);
    rsp_valid[u] = 1'b0; rsp_has_data[u] = 1'b0;
  endtask

  task automatic quiet_check(int u, string rq);
    repeat (3) @(negedge clk);
    chk(cmd_valid[u] == 1'b0, rq, "no cmd while acks pending", int'(cmd_valid[u]), 0);
    chk(req_ready[u] == 1'b0, rq, "busy while acks pending", int'(req_ready[u]), 0);
  endtask

  task automatic t_reset;
    chk(req_ready[0] == 1'b1, "R1", "req_ready", int'(req_ready[0]), 1);
    chk(cmd_valid[0] == 1'b0, "R1", "cmd_valid", int'(cmd_valid[0]), 0);
    chk(rsp_ready[0] == 1'b1, "R1", "rsp_ready", int'(rsp_ready[0]), 1);
  endtask

  task automatic t_read_fill;  // R3, R7, R1 (stored word starts at 0)
    do_req(0, 0, 0, 1, 'h02, 0);
    get_cmd(0, "R3", 0, 1, -1, 1, 0);
    send_ack(0, 0, 0);
    get_cmd(0, "R7", 4, 1, -1, -1, -1);
    do_req(0, 0, 0, 2, 'h02, 0);
    get_cmd(0, "R3", 0, 2, -1, 1, 0);
    send_ack(0, 0, 0);
    get_cmd(0, "R7", 4, 2, -1, -1, -1);
  endtask

  task automatic t_uncached;  // R8
    do_req(0, 1, 1, 3, 'h04, 'hA5A5);
    get_cmd(0, "R8", 6, 3, -1, -1, -1);
    do_req(0, 0, 1, 2, 'h04, 0);
    get_cmd(0, "R8", 5, 2, -1, -1, 'hA5A5);
    // line must still be I with no holders: plain FILL, not FWD
    do_req(0, 0, 0, 0, 'h04, 0);
    get_cmd(0, "R8", 0, 0, -1, 1, 'hA5A5);
    send_ack(0, 0, 0);
    get_cmd(0, "R8", 4, 0, -1, -1, -1);
  endtask

  task automatic t_upgrade;  // R4 holder upgrade, R2 lockout
    do_req(0, 1, 0, 2, 'h02, 0);
    get_cmd(0, "R4", 2, 1, -1, -1, -1);
    quiet_check(0, "R4");
    chk(req_ready[0] == 1'b0, "R2", "second request refused", int'(req_ready[0]), 0);
    send_ack(0, 0, 0);
    get_cmd(0, "R4", 1, 2, -1, 2, -1);
    send_ack(0, 0, 0);
    get_cmd(0, "R7", 4, 2, -1, -1, -1);
  endtask

  task automatic t_read_from_m;  // R5
    do_req(0, 0, 0, 0, 'h02, 0);
    get_cmd(0, "R5", 3, 2, 0, 1, -1);
    send_ack(0, 1, 'h1234);
    get_cmd(0, "R5", 1, 0, -1, 1, -1);
    send_ack(0, 0, 0);
    get_cmd(0, "R5", 4, 0, -1, -1, -1);
    do_req(0, 0, 1, 1, 'h02, 0);
    get_cmd(0, "R5", 5, 1, -1, -1, 'h1234);
  endtask

  task automatic t_multi_inv;  // R4 two sharers, non-holder requester
    do_req(0, 1, 0, 3, 'h02, 0);
    get_cmd(0, "R4", 2, 0, -1, -1, -1);
    get_cmd(0, "R4", 2, 2, -1, -1, -1);
    send_ack(0, 0, 0);
    quiet_check(0, "R4");
    send_ack(0, 0, 0);
    get_cmd(0, "R4", 0, 3, -1, 2, 'h1234);
    send_ack(0, 0, 0);
    get_cmd(0, "R7", 4, 3, -1, -1, -1);
  endtask

  task automatic t_write_from_m;  // R6, R11 (0x03 shares entry with 0x02)
    do_req(0, 1, 0, 1, 'h03, 0);
    chk(int'(cmd_addr[0]) == 0 || 1, "R11", "pre", 0, 0);
    while (!cmd_valid[0]) @(negedge clk);
    chk(int'(cmd_addr[0]) == 'h03, "R11", "cmd_addr echo", int'(cmd_addr[0]), 'h03);
    get_cmd(0, "R6", 3, 3, 1, 0, -1);
    send_ack(0, 1, 'h55);
    get_cmd(0, "R6", 1, 1, -1, 2, -1);
    send_ack(0, 0, 0);
    get_cmd(0, "R7", 4, 1, -1, -1, -1);
    do_req(0, 0, 1, 0, 'h02, 0);
    get_cmd(0, "R11", 5, 0, -1, -1, 'h55);
  endtask

  task automatic t_backpressure;  // R10
    do_req(0, 0, 0, 0, 'h08, 0);
    while (!cmd_valid[0]) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cmd_valid[0] == 1'b1 && cmd_type[0] == 3'd0 && cmd_dest[0] == 2'd0,
          "R10", "held command", int'({cmd_valid[0], cmd_type[0], cmd_dest[0]}), 'h20);
    end
    get_cmd(0, "R10", 0, 0, -1, 1, 0);
    send_ack(0, 0, 0);
    get_cmd(0, "R7", 4, 0, -1, -1, -1);
  endtask

  task automatic t_vi_mode;  // R9
    do_req(1, 0, 0, 0, 'h02, 0);
    get_cmd(1, "R9", 0, 0, -1, 2, 0);
    send_ack(1, 0, 0);
    get_cmd(1, "R9", 4, 0, -1, -1, -1);
    do_req(1, 0, 0, 1, 'h02, 0);
    get_cmd(1, "R9", 3, 0, 1, 0, -1);
    send_ack(1, 1, 7);
    get_cmd(1, "R9", 1, 1, -1, 2, -1);
    send_ack(1, 0, 0);
    get_cmd(1, "R9", 4, 1, -1, -1, -1);
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      req_valid[u] = 0; req_write[u] = 0; req_uncached[u] = 0; req_src[u] = '0;
      req_addr[u] = '0; req_data[u] = '0; cmd_ready[u] = 0;
      rsp_valid[u] = 0; rsp_has_data[u] = 0; rsp_data[u] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_fill();
    t_uncached();
    t_upgrade();
    t_read_from_m();
    t_multi_inv();
    t_write_from_m();
    t_backpressure();
    t_vi_mode();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule